// File: doc/BRIEF.md
# Start-Bit Instruction Boundary Decoder

This block interprets the start-marker field that one header format carries in a 256-bit instruction block. After the 32-bit header come fourteen 16-bit parcels, and the field has one marker bit for each parcel. A set bit means an instruction begins in that parcel. An instruction takes its own parcel and every following parcel up to the next set bit or the end of the field. So a set bit that is followed by another set bit, or that sits in the last position, is a 16-bit short instruction.

For each strobe, the decoder gives the start vector, a 3-bit length code for each parcel, and one error flag. The error flag covers the block rules: too few instructions, an instruction over 96 bits, the reserved leading pattern that marks a different header kind, and, in 64-bit mode, a short first instruction. All results are registered and appear one cycle after the strobe. A fetch front end uses them to steer parcels into per-slot decoders.

Top module: `sbd_boundary_decoder`

## Requirements
- R1: One clock after `valid_i` is high, `valid_o` is high for exactly that cycle. While `valid_i` is low, `start_o`, `len_o` and `err_o` keep their last values.
- R2: `start_o` equals the field that was sampled. Bit i is parcel i, and parcel 0 is the first parcel after the header.
- R3: For each parcel i, `len_o[3*i+2:3*i]` holds a length code. For a start parcel the code is the number of parcels minus one (0=16, 1=32, 2=48, 3=64, 4=80, 5=96 bits). A parcel that is not a start has code 0.
- R4: A set bit followed at once by another set bit, or a set bit in position 13, gives code 0 (16 bits).
- R5: Any other instruction runs from its start parcel up to the parcel before the next set bit, or to the end of the field.
- R6: An instruction longer than 6 parcels gets code 7 and sets `err_o`.
- R7: A field with fewer than two set bits sets `err_o`.
- R8: A field whose low eight bits are 8'b0000_0011 (bits 0 and 1 set, bits 2 to 7 clear) sets `err_o`.
- R9: When `mode64_i` is high and the first instruction has code 0, `err_o` is set. The same field with `mode64_i` low does not set `err_o` for this reason.
- R10: After reset, `valid_o`, `start_o`, `len_o` and `err_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Strobe that samples the field |
| start_bits_i | input | 14 | Start-marker field, bit 0 = first parcel |
| mode64_i | input | 1 | 64-bit mode, enables the short-first-instruction rule |
| valid_o | output | 1 | Results valid, one cycle after the strobe |
| start_o | output | 14 | Registered start vector |
| len_o | output | 42 | Length code for each parcel, 3 bits each |
| err_o | output | 1 | Block rule violation |

## Verification
Every result (start vector, length codes and error flag) is due on the first rising edge after the strobe. Nothing takes longer, because the decode is one combinational layer in front of a single register stage. The bench drives each field on a falling edge. It compares all outputs on the next falling edge against values computed by its own reference functions. Hold behaviour is checked by changing the field with the strobe low and confirming that the outputs from the previous strobe are still there.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
  localparam int unsigned LCW      = 3;
  localparam logic [LCW-1:0] LEN_SHORT = 3'd0;
  localparam logic [LCW-1:0] LEN_OVER  = 3'd7;
  localparam logic [7:0]     LEAD_RSVD = 8'b0000_0011;
endpackage

// File: rtl/sbd_run_len.sv
module sbd_run_len
  import sbd_pkg::*;
#(
  parameter int unsigned NPARC = 14,
  parameter int unsigned MAXP  = 6,
  parameter int unsigned IDX   = 0
) (
  input  logic [NPARC-1:0] field_i,
  output logic [LCW-1:0]   code_o
);
  localparam int unsigned CW = $clog2(NPARC + 1) + 1;

  logic [CW-1:0] cnt;
  logic          stop;

  always_comb begin
    cnt  = CW'(1);
    stop = 1'b0;
    for (int j = IDX + 1; j < NPARC; j++) begin
      if (!stop) begin
        if (field_i[j]) stop = 1'b1;
        else            cnt  = cnt + CW'(1);
      end
    end
    if (!field_i[IDX])          code_o = '0;
    else if (cnt > CW'(MAXP))   code_o = LEN_OVER;
    else                        code_o = LCW'(cnt - CW'(1));
  end
endmodule

// File: rtl/sbd_rules.sv
module sbd_rules
  import sbd_pkg::*;
#(
  parameter int unsigned NPARC = 14
) (
  input  logic [NPARC-1:0]     field_i,
  input  logic [NPARC*LCW-1:0] codes_i,
  input  logic                 mode64_i,
  output logic                 err_o
);
  logic too_few, too_long, lead_rsvd, short_first, found;
  logic [LCW-1:0] first_code;

  always_comb begin
    too_long   = 1'b0;
    found      = 1'b0;
    first_code = '0;
    for (int i = 0; i < NPARC; i++) begin
      if (codes_i[i*LCW +: LCW] == LEN_OVER) too_long = 1'b1;
      if (field_i[i] && !found) begin
        found      = 1'b1;
        first_code = codes_i[i*LCW +: LCW];
      end
    end
    too_few     = $countones(field_i) < 2;
    lead_rsvd   = field_i[7:0] == LEAD_RSVD;
    short_first = mode64_i && found && first_code == LEN_SHORT;
    err_o       = too_few | too_long | lead_rsvd | short_first;
  end
endmodule

// File: rtl/sbd_boundary_decoder.sv
module sbd_boundary_decoder
  import sbd_pkg::*;
#(
  parameter int unsigned NPARC = 14,
  parameter int unsigned MAXP  = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [NPARC-1:0]     start_bits_i,
  input  logic                 mode64_i,
  output logic                 valid_o,
  output logic [NPARC-1:0]     start_o,
  output logic [NPARC*LCW-1:0] len_o,
  output logic                 err_o
);
  logic [NPARC*LCW-1:0] codes;
  logic                 err_d;

  for (genvar g = 0; g < NPARC; g++) begin : g_run
    sbd_run_len #(.NPARC(NPARC), .MAXP(MAXP), .IDX(g)) i_run (
      .field_i (start_bits_i),
      .code_o  (codes[g*LCW +: LCW])
    );
  end

  sbd_rules #(.NPARC(NPARC)) i_rules (
    .field_i  (start_bits_i),
    .codes_i  (codes),
    .mode64_i (mode64_i),
    .err_o    (err_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      start_o <= '0;
      len_o   <= '0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        start_o <= start_bits_i;
        len_o   <= codes;
        err_o   <= err_d;
      end
    end
  end
endmodule

// File: rtl/sbd_boundary_checker.sv
module sbd_boundary_checker #(
  parameter int unsigned NPARC = 14
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic [NPARC-1:0]     start_bits_i,
  input logic                 mode64_i,
  input logic                 valid_o,
  input logic [NPARC-1:0]     start_o,
  input logic [NPARC*3-1:0]   len_o,
  input logic                 err_o
);
  logic stray_len;
  always_comb begin
    stray_len = 1'b0;
    for (int i = 0; i < NPARC; i++)
      if (!start_o[i] && len_o[i*3 +: 3] != 3'd0) stray_len = 1'b1;
  end

  p_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(start_o) && $stable(len_o) && $stable(err_o));
  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> start_o == $past(start_bits_i));
  p_nonstart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !stray_len);
  p_few_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && $countones(start_bits_i) < 2 |=> err_o);
  p_lead_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && start_bits_i[7:0] == 8'b0000_0011 |=> err_o);
  p_short_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mode64_i && start_bits_i[0] && start_bits_i[1] |=> err_o);
endmodule

bind sbd_boundary_decoder sbd_boundary_checker #(.NPARC(NPARC)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .start_bits_i(start_bits_i),
  .mode64_i(mode64_i), .valid_o(valid_o), .start_o(start_o), .len_o(len_o),
  .err_o(err_o)
);

// File: tb/test_sbd_boundary_decoder.sv
module test_sbd_boundary_decoder;
  localparam int N = 14;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [N-1:0]  start_bits_i = '0;
  logic          mode64_i = 1'b0;
  logic          valid_o;
  logic [N-1:0]  start_o;
  logic [N*3-1:0] len_o;
  logic          err_o;
  int            checks = 0;
  int            errors = 0;

  always #4 clk_i = ~clk_i;

  sbd_boundary_decoder i_sbd_boundary_decoder (.*);

  function automatic logic [2:0] ref_code(logic [N-1:0] f, int i);
    int n = 1;
    if (!f[i]) return 3'd0;
    for (int j = i + 1; j < N; j++) begin
      if (f[j]) break;
      n++;
    end
    return (n > 6) ? 3'd7 : 3'(n - 1);
  endfunction

  function automatic logic [N*3-1:0] ref_len(logic [N-1:0] f);
    logic [N*3-1:0] r = '0;
    for (int i = 0; i < N; i++) r[i*3 +: 3] = ref_code(f, i);
    return r;
  endfunction

  function automatic logic ref_err(logic [N-1:0] f, logic m64);
    logic e = 1'b0;
    int first = -1;
    for (int i = 0; i < N; i++) begin
      if (ref_code(f, i) == 3'd7) e = 1'b1;
      if (f[i] && first < 0) first = i;
    end
    if ($countones(f) < 2) e = 1'b1;
    if (f[7:0] == 8'b0000_0011) e = 1'b1;
    if (m64 && first >= 0 && ref_code(f, first) == 3'd0) e = 1'b1;
    return e;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(string tag, logic [N-1:0] f, logic m64);
    valid_i = 1'b1; start_bits_i = f; mode64_i = m64;
    @(negedge clk_i);
    valid_i = 1'b0;
    check({tag, " valid R1"}, 64'(valid_o), 64'd1);
    check({tag, " start R2"}, 64'(start_o), 64'(f));
    check({tag, " len R3"}, 64'(len_o), 64'(ref_len(f)));
    check({tag, " err"}, 64'(err_o), 64'(ref_err(f, m64)));
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk_i);
    check("reset R10", {20'd0, valid_o, start_o, len_o[28:0]}, 64'd0);
    check("reset R10 hi", 64'({len_o[41:29], err_o}), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    apply("all short R4", 14'h3FFF, 1'b0);
    check("all short no err R9", 64'(err_o), 64'd0);
    apply("short first m64 R9", 14'h3FFF, 1'b1);
    check("short first m64 R9", 64'(err_o), 64'd1);
    apply("last parcel R4", 14'h2AAA, 1'b0);
    check("last parcel code R4", 64'(len_o[41:39]), 64'd0);
    apply("max 96 R5", 14'h1041, 1'b1);
    check("max 96 code R5", 64'(len_o[2:0]), 64'd5);
    check("max 96 ok R6", 64'(err_o), 64'd0);
    apply("over 96 R6", 14'h2081, 1'b0);
    check("over 96 code R6", 64'(len_o[2:0]), 64'd7);
    apply("single R7", 14'h0001, 1'b0);
    check("single err R7", 64'(err_o), 64'd1);
    apply("none R7", 14'h0000, 1'b0);
    apply("lead R8", 14'h3F03, 1'b0);
    check("lead err R8", 64'(err_o), 64'd1);
    // hold with strobe low
    start_bits_i = 14'h1555; mode64_i = 1'b1;
    @(negedge clk_i);
    check("hold valid R1", 64'(valid_o), 64'd0);
    check("hold start R1", 64'(start_o), 64'h3F03);
    check("hold err R1", 64'(err_o), 64'd1);
    for (int k = 0; k < 400; k++) begin
      logic [N-1:0] f = N'($urandom);
      if (k % 3 == 0) f = f | N'($urandom);
      apply("random R5", f, 1'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule